// File: doc/BRIEF.md
# Four-Channel Bridge PWM Steering Unit

This block turns one pulse-width modulated signal into the drive pattern for up to four output channels, A to D. A free-running counter sets the period. A 10-bit duty value sets how long each period stays active. A 2-bit configuration field chooses what the channels do:

- a single modulated channel;
- a half-bridge pair with complementary outputs and dead time;
- an H-bridge driven forward, with one corner modulated and the opposite corner held on;
- an H-bridge driven in reverse, the same pattern mirrored.

A 2-bit polarity field sets the active level of the A/C pair and of the B/D pair separately. A channel that the chosen configuration does not use has its output enable low. The pad logic can then hand that pin back to general-purpose use.

The duty value arrives as an 8-bit high part and a 2-bit low part. A new duty value takes effect only when the next period starts, and so do the period, configuration, polarity and dead-time values. Until then the running period keeps its old settings. When the enable input is low, the unit is held in its off state. All enables are low, all levels are low, and the counter waits at zero.

Top module: `pwm_bridge_steer`

## Requirements
- R1: The duty value is {duty_hi, duty_lo}, with duty_hi as bits 9..2. A period value P (P >= 1; 0 acts as 1) gives a period of P clocks with counts 0..P-1. The modulated signal is active during the first D clocks of each period (count < D).
- R2: A duty of zero gives no active clocks. A duty equal to or above P gives an active level during every clock of the period.
- R3: Configuration 0 (single): only channel A is modulated. pin_oe = 4'b0001, where bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. The released channels drive level 0.
- R4: Configuration 1 (forward bridge): D is modulated, A is held active, B and C are held inactive, and pin_oe = 4'b1111.
- R5: Configuration 2 (half-bridge): A follows the modulated signal and B follows its complement. pin_oe = 4'b0011, and C and D are released.
- R6: Configuration 3 (reverse bridge): B is modulated, C is held active, A and D are held inactive, and pin_oe = 4'b1111.
- R7: In half-bridge mode, each output turns on only dead_time clocks (0..127) after the modulated signal switches towards it. Its turn-off is immediate, so A and B are never active in the same clock.
- R8: Polarity bit 1 set makes A and C active-low. Polarity bit 0 set makes B and D active-low. A cleared bit means active-high. Each driven pin shows its inactive level when it is not active.
- R9: Duty, period, configuration, polarity and dead time are sampled at a period boundary. A change made mid-period affects neither the levels nor the enables until the next period starts.
- R10: While enable is low, pin_oe and pin are all zero and the counter is held at zero. The first enabled clock is count 0 of a fresh period and uses the values presented before it.
- R11: While rst_n is low, pin_oe and pin are all zero, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Unit on; low holds the unit off and releases all channels |
| duty_hi | input | 8 | Upper eight bits of the duty value |
| duty_lo | input | 2 | Lower two bits of the duty value |
| period | input | 10 | Period length in clocks |
| out_cfg | input | 2 | Channel configuration: 0 single, 1 forward, 2 half-bridge, 3 reverse |
| polarity | input | 2 | Bit 1: A/C active-low; bit 0: B/D active-low |
| dead_time | input | 7 | Half-bridge turn-on delay in clocks |
| pin | output | 4 | Channel levels, bit 0 = A through bit 3 = D |
| pin_oe | output | 4 | Channel output enables, same bit order |

## Verification
The modulated channel is measured by counting its active clocks over exactly one period, for these duty values:
- 9, loaded as a split high/low value, which exposes a swapped or misplaced low part;
- zero, which shows whether a compare is off by one at the bottom;
- a value equal to the period and one far above it, which do the same at the top.

Each bridge configuration is run with more than one polarity setting. The counts of held-active and held-inactive channels then separate a wrong steering table from a wrong polarity pair. The half-bridge runs once with zero dead time and once with three clocks of dead time. In the zero case the two channels must add up to the period; in the three-clock case each loses three clocks and the two never overlap. A mid-period change of duty and configuration tells double-buffered loading apart from immediate loading.

// File: rtl/pwm_steer_pkg.sv
// Shared definitions for the bridge PWM steering unit.
// Assumes: configuration encoding fixed by the out_cfg input field.
package pwm_steer_pkg;

    localparam int NUM_CH = 4;

    typedef enum logic [1:0] {
        CFG_SINGLE = 2'd0,
        CFG_FWD    = 2'd1,
        CFG_HALF   = 2'd2,
        CFG_REV    = 2'd3
    } steer_cfg_e;

endpackage

// File: rtl/pwm_timebase.sv
// Period counter, shadow registers and duty compare.
// What it does: counts 0..period-1, reloads all settings at each period
// boundary (or every clock while disabled) and raises raw while count < duty.
// Assumes: a period of 0 behaves as 1; enable low restarts the period.
module pwm_timebase
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int DEAD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  duty_in,
    input  logic [CNT_W-1:0]  period_in,
    input  logic [1:0]        cfg_in,
    input  logic [1:0]        pol_in,
    input  logic [DEAD_W-1:0] dead_in,
    output steer_cfg_e        cfg_s,
    output logic [1:0]        pol_s,
    output logic [DEAD_W-1:0] dead_s,
    output logic              term,
    output logic              raw
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_s;
    logic [CNT_W-1:0] period_s;

    // End of period: last count, or every clock for a period of 0 or 1.
    always_comb begin
        if (period_s <= CNT_W'(1))
            term = 1'b1;
        else
            term = (cnt == period_s - CNT_W'(1));
    end

    // Modulated signal: active in the first duty_s counts of the period.
    always_comb raw = enable && (cnt < duty_s);

    // Counter advance and shadow reload at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            duty_s   <= '0;
            period_s <= '0;
            cfg_s    <= CFG_SINGLE;
            pol_s    <= '0;
            dead_s   <= '0;
        end else if (!enable || term) begin
            cnt      <= '0;
            duty_s   <= duty_in;
            period_s <= period_in;
            cfg_s    <= steer_cfg_e'(cfg_in);
            pol_s    <= pol_in;
            dead_s   <= dead_in;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // The count never reaches the period value.
    p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && period_s > CNT_W'(1)) |-> (cnt < period_s));

    // Disabling restarts the period from zero.
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));

    // Settings do not move inside a period.
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !term) |=> ($stable(duty_s) && $stable(period_s) &&
                               $stable(cfg_s) && $stable(pol_s)));

endmodule

// File: rtl/pwm_deadband.sv
// Complementary pair generator with turn-on delay.
// What it does: side 0 follows raw, side 1 follows its complement; each side
// turns on only after its drive has been high for dead clocks, off at once.
// Assumes: hold counters saturate, so any dead value up to all-ones works.
module pwm_deadband #(
    parameter int DEAD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              raw,
    input  logic [DEAD_W-1:0] dead,
    output logic              a_on,
    output logic              b_on
);

    logic [1:0] drive;
    logic [1:0] on;

    // Side 0 wants raw, side 1 wants its complement.
    always_comb drive = {~raw, raw};

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic [DEAD_W-1:0] hold;

        // Count how long this side has been requested, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n || !enable || !drive[s])
                hold <= '0;
            else if (hold != {DEAD_W{1'b1}})
                hold <= hold + DEAD_W'(1);
        end

        // Turn on once the dead time has elapsed.
        always_comb on[s] = enable && drive[s] && (hold >= dead);
    end

    always_comb begin
        a_on = on[0];
        b_on = on[1];
    end

    // With a non-zero dead time A cannot start in the clock B stops.
    p_gap_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(b_on) && enable && dead != '0) |-> !a_on);

    p_gap_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(a_on) && enable && dead != '0) |-> !b_on);

endmodule

// File: rtl/pwm_chan_map.sv
// Channel steering and polarity.
// What it does: maps the modulated and dead-banded signals onto channels
// A..D per configuration, sets enables, and applies per-pair polarity.
// Assumes: bit 0 = A .. bit 3 = D; even channels use pol[1], odd use pol[0].
module pwm_chan_map
    import pwm_steer_pkg::*;
(
    input  logic              run,
    input  steer_cfg_e        cfg,
    input  logic [1:0]        pol,
    input  logic              raw,
    input  logic              a_on,
    input  logic              b_on,
    output logic [NUM_CH-1:0] pin,
    output logic [NUM_CH-1:0] pin_oe
);

    logic [NUM_CH-1:0] act;
    logic [NUM_CH-1:0] oe_cfg;

    // Steering table: logical activity and enables per configuration.
    always_comb begin
        act    = '0;
        oe_cfg = '0;
        unique case (cfg)
            CFG_SINGLE: begin
                act    = {3'b000, raw};
                oe_cfg = 4'b0001;
            end
            CFG_FWD: begin
                act    = {raw, 2'b00, 1'b1};
                oe_cfg = 4'b1111;
            end
            CFG_HALF: begin
                act    = {2'b00, b_on, a_on};
                oe_cfg = 4'b0011;
            end
            CFG_REV: begin
                act    = {1'b0, 1'b1, raw, 1'b0};
                oe_cfg = 4'b1111;
            end
            default: begin
                act    = '0;
                oe_cfg = '0;
            end
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pol
        localparam int PB = (i % 2 == 0) ? 1 : 0;
        // Drive the active level per pair polarity; release when unused.
        always_comb begin
            pin_oe[i] = run && oe_cfg[i];
            pin[i]    = pin_oe[i] && (act[i] ^ pol[PB]);
        end
    end

endmodule

// File: rtl/pwm_bridge_steer.sv
// Top level of the four-channel bridge PWM steering unit.
// What it does: ties the timebase, dead-band pair and channel map together.
// Assumes: all inputs synchronous to clk; rst_n is synchronous active-low.
module pwm_bridge_steer
    import pwm_steer_pkg::*;
#(
    parameter int DUTY_HI_W = 8,
    parameter int DUTY_LO_W = 2,
    parameter int DEAD_W    = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic [DUTY_HI_W-1:0]           duty_hi,
    input  logic [DUTY_LO_W-1:0]           duty_lo,
    input  logic [DUTY_HI_W+DUTY_LO_W-1:0] period,
    input  logic [1:0]                     out_cfg,
    input  logic [1:0]                     polarity,
    input  logic [DEAD_W-1:0]              dead_time,
    output logic [NUM_CH-1:0]              pin,
    output logic [NUM_CH-1:0]              pin_oe
);

    localparam int CNT_W = DUTY_HI_W + DUTY_LO_W;

    logic              run;
    logic [CNT_W-1:0]  duty_full;
    steer_cfg_e        cfg_s;
    logic [1:0]        pol_s;
    logic [DEAD_W-1:0] dead_s;
    logic              term;
    logic              raw;
    logic              a_on;
    logic              b_on;

    // Unit runs only out of reset and while enabled.
    always_comb run = enable && rst_n;

    // Join the split duty value, high part on top.
    always_comb duty_full = {duty_hi, duty_lo};

    pwm_timebase #(
        .CNT_W  (CNT_W),
        .DEAD_W (DEAD_W)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .duty_in   (duty_full),
        .period_in (period),
        .cfg_in    (out_cfg),
        .pol_in    (polarity),
        .dead_in   (dead_time),
        .cfg_s     (cfg_s),
        .pol_s     (pol_s),
        .dead_s    (dead_s),
        .term      (term),
        .raw       (raw)
    );

    pwm_deadband #(
        .DEAD_W (DEAD_W)
    ) u_deadband (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .raw    (raw),
        .dead   (dead_s),
        .a_on   (a_on),
        .b_on   (b_on)
    );

    pwm_chan_map u_map (
        .run    (run),
        .cfg    (cfg_s),
        .pol    (pol_s),
        .raw    (raw),
        .a_on   (a_on),
        .b_on   (b_on),
        .pin    (pin),
        .pin_oe (pin_oe)
    );

    // Enables only change at a period boundary while running.
    p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$past(term)) |-> $stable(pin_oe));

    // A released channel never shows a high level.
    p_released_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin & ~pin_oe) == '0));

    // Off state releases every channel on the next clock too.
    p_off_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (pin_oe == '0));

endmodule

// File: tb/pwm_bridge_steer_bench.sv
// Directed bench for the bridge PWM steering unit.
module pwm_bridge_steer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] duty_hi = '0;
    logic [1:0] duty_lo = '0;
    logic [9:0] period = '0;
    logic [1:0] out_cfg = '0;
    logic [1:0] polarity = '0;
    logic [6:0] dead_time = '0;
    logic [3:0] pin;
    logic [3:0] pin_oe;

    int total = 0;
    int bad = 0;
    int hi_cnt [4];
    int overlap;
    logic [3:0] oe_last;
    int oe_moves;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bridge_steer u_pwm_bridge_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .duty_hi   (duty_hi),
        .duty_lo   (duty_lo),
        .period    (period),
        .out_cfg   (out_cfg),
        .polarity  (polarity),
        .dead_time (dead_time),
        .pin       (pin),
        .pin_oe    (pin_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load settings while off, then switch on; returns in cycle 0, sampled.
    task automatic start(input int cfg, input int pol, input int duty,
                         input int per, input int dead);
        @(negedge clk);
        enable    = 1'b0;
        out_cfg   = 2'(cfg);
        polarity  = 2'(pol);
        duty_hi   = 8'(duty >> 2);
        duty_lo   = 2'(duty);
        period    = 10'(per);
        dead_time = 7'(dead);
        @(negedge clk);
        enable = 1'b1;
        #1;
    endtask

    // Count high clocks per pin over n cycles, starting at the current sample.
    task automatic measure(input int n);
        for (int c = 0; c < 4; c++) hi_cnt[c] = 0;
        overlap  = 0;
        oe_moves = 0;
        oe_last  = pin_oe;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < 4; c++) hi_cnt[c] += int'(pin[c]);
            if (pin[0] && pin[1]) overlap++;
            if (pin_oe != oe_last) oe_moves++;
            oe_last = pin_oe;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        enable = 1'b1;
        out_cfg = 2'd1;
        duty_hi = 8'd3;
        period = 10'd8;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(pin_oe == 4'b0000, "R11 oe in reset", pin_oe, 0);
        check(pin == 4'b0000, "R11 pin in reset", pin, 0);
        @(negedge clk);
        enable = 1'b0;
        rst_n = 1'b1;
        #1;
        check(pin_oe == 4'b0000, "R10 oe while off", pin_oe, 0);
    endtask

    task automatic t_single();
        start(0, 0, 9, 20, 0);
        measure(20);
        check(hi_cnt[0] == 9, "R1 A active clocks duty 9", hi_cnt[0], 9);
        check(oe_last == 4'b0001, "R3 single oe", oe_last, 1);
        check(hi_cnt[1] + hi_cnt[2] + hi_cnt[3] == 0, "R3 released pins low",
              hi_cnt[1] + hi_cnt[2] + hi_cnt[3], 0);
    endtask

    task automatic t_duty_edges();
        start(0, 0, 0, 10, 0);
        measure(10);
        check(hi_cnt[0] == 0, "R2 duty zero", hi_cnt[0], 0);
        start(0, 0, 10, 10, 0);
        measure(10);
        check(hi_cnt[0] == 10, "R2 duty equals period", hi_cnt[0], 10);
        start(0, 0, 1023, 10, 0);
        measure(10);
        check(hi_cnt[0] == 10, "R2 duty above period", hi_cnt[0], 10);
    endtask

    task automatic t_forward();
        start(1, 0, 6, 16, 0);
        measure(16);
        check(hi_cnt[0] == 16, "R4 A held active", hi_cnt[0], 16);
        check(hi_cnt[1] == 0 && hi_cnt[2] == 0, "R4 B C inactive",
              hi_cnt[1] + hi_cnt[2], 0);
        check(hi_cnt[3] == 6, "R4 D modulated", hi_cnt[3], 6);
        check(oe_last == 4'b1111, "R4 oe", oe_last, 15);
        start(1, 1, 6, 16, 0);
        measure(16);
        check(hi_cnt[1] == 16, "R8 B inactive level high when active-low", hi_cnt[1], 16);
        check(hi_cnt[3] == 10, "R8 D active-low high clocks", hi_cnt[3], 10);
        check(hi_cnt[0] == 16, "R8 A active-high held", hi_cnt[0], 16);
    endtask

    task automatic t_reverse();
        start(3, 0, 5, 12, 0);
        measure(12);
        check(hi_cnt[1] == 5, "R6 B modulated", hi_cnt[1], 5);
        check(hi_cnt[2] == 12, "R6 C held active", hi_cnt[2], 12);
        check(hi_cnt[0] == 0 && hi_cnt[3] == 0, "R6 A D inactive",
              hi_cnt[0] + hi_cnt[3], 0);
        check(oe_last == 4'b1111, "R6 oe", oe_last, 15);
        start(3, 2, 5, 12, 0);
        measure(12);
        check(hi_cnt[0] == 12, "R8 A inactive high when active-low", hi_cnt[0], 12);
        check(hi_cnt[2] == 0, "R8 C active-low held active", hi_cnt[2], 0);
        check(hi_cnt[1] == 5, "R8 B active-high unchanged", hi_cnt[1], 5);
    endtask

    task automatic t_half();
        start(2, 0, 8, 20, 0);
        measure(20);
        check(hi_cnt[0] == 8, "R5 A follows duty", hi_cnt[0], 8);
        check(hi_cnt[1] == 12, "R5 B complement", hi_cnt[1], 12);
        check(oe_last == 4'b0011, "R5 oe", oe_last, 3);
        start(2, 3, 8, 20, 0);
        measure(20);
        check(hi_cnt[0] == 12, "R8 A active-low high clocks", hi_cnt[0], 12);
        check(hi_cnt[1] == 8, "R8 B active-low high clocks", hi_cnt[1], 8);
        start(2, 0, 8, 20, 3);
        measure(20);
        check(hi_cnt[0] == 5, "R7 A loses dead time", hi_cnt[0], 5);
        check(hi_cnt[1] == 9, "R7 B loses dead time", hi_cnt[1], 9);
        check(overlap == 0, "R7 no overlap", overlap, 0);
    endtask

    task automatic t_buffer();
        start(0, 0, 4, 20, 0);
        for (int c = 0; c < 4; c++) hi_cnt[c] = 0;
        oe_moves = 0;
        oe_last  = pin_oe;
        for (int k = 0; k < 20; k++) begin
            hi_cnt[0] += int'(pin[0]);
            if (pin_oe != oe_last) oe_moves++;
            if (k == 2) begin
                duty_hi = 8'd3;
                out_cfg = 2'd1;
            end
            @(negedge clk);
            #1;
        end
        check(hi_cnt[0] == 4, "R9 old duty kept in period", hi_cnt[0], 4);
        check(oe_moves == 0, "R9 oe unchanged mid period", oe_moves, 0);
        check(pin_oe == 4'b1111, "R9 new cfg at boundary", pin_oe, 15);
        measure(20);
        check(hi_cnt[3] == 12, "R9 new duty next period", hi_cnt[3], 12);
        @(negedge clk);
        enable = 1'b0;
        #1;
        check(pin_oe == 4'b0000 && pin == 4'b0000, "R10 off releases",
              {pin_oe, pin}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_duty_edges();
        t_forward();
        t_reverse();
        t_half();
        t_buffer();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule